// File: doc/BRIEF.md
# Programmable Interrupt Priority Router

This block sits between three on-chip interrupt sources (a counter/timer, a serial unit and a parallel port) and the processor's single interrupt request line. It chains them behind one another with a run-time selectable order, and it hangs a chain of external sources behind the last internal one. The block drives one request to the processor. When the processor runs an acknowledge cycle, the block picks the highest-ranked source that may request and returns that source's 8-bit vector.

The internal order is chosen by a three-bit priority code. Software writes the code through an I/O port, and the port is decoded on the low address byte only. A source that has been acknowledged stays in service until a return-from-interrupt names it. While it is in service, every source ranked below it is held off, and a source ranked above it may still nest. The external chain gets an enable signal. It may only request when no internal source is pending or in service.

Top module: `irq_prio_router`

## Requirements
- R1: After reset the priority code is 0, no source is in service, `intReq` is low with no pending input, and `extEnIn` is high.
- R2: A write with `ioWrEn` high and `ioAddr[7:0]` equal to 0xF4 loads `ioWrData[2:0]`, whatever `ioAddr[15:8]` holds. A write to any other low address byte leaves the code unchanged. The new code governs arbitration from the next clock on.
- R3: Source indices are timer=0, serial=1, parallel=2, and each order is listed from highest rank to lowest. Code 0 gives 0,1,2. Code 1 gives 1,0,2. Code 2 gives 0,2,1. Code 3 gives 2,1,0. Code 4 gives 2,0,1. Code 5 gives 1,2,0.
- R4: Written code 6 behaves as code 2, and written code 7 behaves as code 3.
- R5: The external chain ranks below all internal sources. `extEnIn` is high only when no internal source is pending or in service, and the external request counts only while `extEnIn` is high.
- R6: `intReq` is high exactly when some internal source is pending, not in service and not ranked below an in-service source, or when the external request counts.
- R7: While `ackValid` is high, `ackGrant` (bits 0..2 are the internal sources, bit 3 is the external chain) is one-hot on the winning source and `ackVec` carries that source's vector. With no request, both are zero.
- R8: A granted internal source is in service from the next clock. Sources ranked below it cannot request until it leaves service, while a source ranked above it can still be granted.
- R9: `retiValid` with `retiSel` 0..2 clears that source's in-service flag on the next clock. `retiSel`=3 leaves the internal flags unchanged. An acknowledge and a return in the same cycle both take effect.
- R10: A code change keeps every in-service flag. From the next clock, blocking follows the new order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O port address |
| ioWrEn | input | 1 | I/O write strobe |
| ioWrData | input | 8 | I/O write data |
| srcPend | input | 3 | Pending flags of timer, serial, parallel |
| srcVec | input | 24 | Vectors, source n at bits [8n+7:8n] |
| extPend | input | 1 | Request from the external chain |
| extVec | input | 8 | Vector of the external chain |
| ackValid | input | 1 | Acknowledge cycle in progress |
| retiValid | input | 1 | Return-from-interrupt seen |
| retiSel | input | 2 | Source that is returning (3 = external) |
| intReq | output | 1 | Interrupt request to the processor |
| extEnIn | output | 1 | Enable into the external chain |
| ackGrant | output | 4 | One-hot grant during acknowledge |
| ackVec | output | 8 | Vector of the granted source |

## Verification
Two pairs of events can land in the same cycle. A priority write can coincide with an acknowledge, and an acknowledge can coincide with a return-from-interrupt. The bench provokes both pairs, first in directed steps and then in a long pseudo-random run where writes, acknowledges and returns overlap freely. A bench model judges every cycle. It arbitrates with the code in force before the edge, and it applies the clear and the set to the in-service flags together at that edge. Every combination of code and pending pattern is swept as well.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_SRC   = 3;
  localparam int VEC_W     = 8;
  localparam int ADDR_W    = 16;
  localparam int DEC_W     = 8;
  localparam int CODE_W    = 3;
  localparam int SEL_W     = 2;
  localparam logic [DEC_W-1:0] PRIO_PORT = 8'hF4;
  localparam int ORD_W     = NUM_SRC * SEL_W;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              ackStb;
    logic              retiStb;
    logic [SEL_W-1:0]  retiSel;
  } irq_ctl_t;

  // Packed order, rank 0 in the low field; source ids timer=0 serial=1 parallel=2 (R3)
  function automatic logic [ORD_W-1:0] orderOf(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    orderOf = {2'd2, 2'd0, 2'd1};
      3'd2:    orderOf = {2'd1, 2'd2, 2'd0};
      3'd3:    orderOf = {2'd0, 2'd1, 2'd2};
      3'd4:    orderOf = {2'd1, 2'd0, 2'd2};
      3'd5:    orderOf = {2'd0, 2'd2, 2'd1};
      default: orderOf = {2'd2, 2'd1, 2'd0};
    endcase
  endfunction
endpackage

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic [VEC_W-1:0]  ioWrData,
  input  logic              ackValid,
  input  logic              retiValid,
  input  logic [SEL_W-1:0]  retiSel,
  output irq_ctl_t          ctl
);
  localparam int LEGAL_MAX = 5;

  logic [CODE_W-1:0] codeQ;
  logic [CODE_W-1:0] rawCode;
  logic              portHit;

  assign portHit = ioWrEn && (ioAddr[DEC_W-1:0] == PRIO_PORT);
  assign rawCode = ioWrData[CODE_W-1:0];

  // Undefined codes fold onto their low two bits (R4); reset code 0 (R1)
  always_ff @(posedge clk) begin
    if (!rstN)        codeQ <= '0;
    else if (portHit) codeQ <= (rawCode > CODE_W'(LEGAL_MAX)) ? {1'b0, rawCode[1:0]} : rawCode;
  end

  assign ctl.code    = codeQ;
  assign ctl.ackStb  = ackValid;
  assign ctl.retiStb = retiValid;
  assign ctl.retiSel = retiSel;

  assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    codeQ <= CODE_W'(LEGAL_MAX));

  assert_ignore_port_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioAddr[DEC_W-1:0] != PRIO_PORT) |=> $stable(codeQ));

  assert_load_port_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioAddr[DEC_W-1:0] == PRIO_PORT && ioWrData[2:0] < 3'd6) |=> codeQ == $past(ioWrData[2:0]));
endmodule

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  irq_ctl_t                 ctl,
  input  logic [NUM_SRC-1:0]       srcPend,
  input  logic [NUM_SRC*VEC_W-1:0] srcVec,
  input  logic                     extPend,
  input  logic [VEC_W-1:0]         extVec,
  output logic                     intReq,
  output logic                     extEnIn,
  output logic [NUM_SRC:0]         ackGrant,
  output logic [VEC_W-1:0]         ackVec
);
  logic [ORD_W-1:0]   ordPack;
  logic [NUM_SRC-1:0] inSvc;
  logic [NUM_SRC-1:0] winInt;
  logic               anyInt;
  logic               extReq;
  logic [NUM_SRC:0]   winAll;
  logic [VEC_W-1:0]   vecTerm [NUM_SRC+1];

  assign ordPack = orderOf(ctl.code);

  // Walk the ranks: first unblocked pending source wins; in-service blocks below (R6, R8)
  always_comb begin
    logic             blk;
    logic [SEL_W-1:0] s;
    blk    = 1'b0;
    winInt = '0;
    anyInt = 1'b0;
    for (int p = 0; p < NUM_SRC; p++) begin
      s = ordPack[p*SEL_W +: SEL_W];
      if (!anyInt && !blk && srcPend[s] && !inSvc[s]) begin
        winInt[s] = 1'b1;
        anyInt    = 1'b1;
      end
      blk = blk | inSvc[s];
    end
  end

  // External chain sits behind every internal source (R5)
  assign extEnIn  = ~(|srcPend) & ~(|inSvc);
  assign extReq   = extPend & extEnIn;
  assign winAll   = {extReq & ~anyInt, winInt};
  assign intReq   = anyInt | extReq;
  assign ackGrant = ctl.ackStb ? winAll : '0;

  // In-service flags; code changes never touch them (R10)
  always_ff @(posedge clk) begin
    if (!rstN) inSvc <= '0;
    else begin
      for (int g = 0; g < NUM_SRC; g++) begin
        if (ctl.ackStb && winInt[g])                              inSvc[g] <= 1'b1;
        else if (ctl.retiStb && ctl.retiSel == SEL_W'(g))         inSvc[g] <= 1'b0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_vec
      assign vecTerm[g] = srcVec[g*VEC_W +: VEC_W] & {VEC_W{ackGrant[g]}};

      assert_ack_marks_R8: assert property (@(posedge clk) disable iff (!rstN)
        ackGrant[g] |=> inSvc[g]);

      assert_reti_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
        (ctl.retiStb && ctl.retiSel == SEL_W'(g) && !ackGrant[g]) |=> !inSvc[g]);
    end
  endgenerate
  assign vecTerm[NUM_SRC] = extVec & {VEC_W{ackGrant[NUM_SRC]}};

  always_comb begin
    ackVec = '0;
    for (int k = 0; k <= NUM_SRC; k++) ackVec = ackVec | vecTerm[k];
  end

  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackGrant));

  assert_ext_below_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackGrant[NUM_SRC] |-> (srcPend == '0 && inSvc == '0));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (srcPend == '0 && !extPend) |-> !intReq);

  assert_grant_needs_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid_any(ackGrant)) |-> intReq);

  function automatic logic ackValid_any(input logic [NUM_SRC:0] gr);
    return |gr;
  endfunction
endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router
  import irq_prio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [15:0]  ioAddr,
  input  logic         ioWrEn,
  input  logic [7:0]   ioWrData,
  input  logic [2:0]   srcPend,
  input  logic [23:0]  srcVec,
  input  logic         extPend,
  input  logic [7:0]   extVec,
  input  logic         ackValid,
  input  logic         retiValid,
  input  logic [1:0]   retiSel,
  output logic         intReq,
  output logic         extEnIn,
  output logic [3:0]   ackGrant,
  output logic [7:0]   ackVec
);
  irq_ctl_t ctl;

  irq_prio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioWrData(ioWrData),
    .ackValid(ackValid), .retiValid(retiValid), .retiSel(retiSel), .ctl(ctl)
  );

  irq_prio_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .srcPend(srcPend), .srcVec(srcVec),
    .extPend(extPend), .extVec(extVec), .intReq(intReq), .extEnIn(extEnIn),
    .ackGrant(ackGrant), .ackVec(ackVec)
  );
endmodule

// File: tb/irq_prio_router_bench.sv
module irq_prio_router_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] ioAddr;
  logic        ioWrEn;
  logic [7:0]  ioWrData;
  logic [2:0]  srcPend;
  logic [23:0] srcVec;
  logic        extPend;
  logic [7:0]  extVec;
  logic        ackValid;
  logic        retiValid;
  logic [1:0]  retiSel;
  logic        intReq;
  logic        extEnIn;
  logic [3:0]  ackGrant;
  logic [7:0]  ackVec;

  int checks = 0;
  int errors = 0;
  logic [2:0] mCode;
  logic [2:0] mSvc;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  irq_prio_router u_irq_prio_router (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioWrData(ioWrData),
    .srcPend(srcPend), .srcVec(srcVec), .extPend(extPend), .extVec(extVec),
    .ackValid(ackValid), .retiValid(retiValid), .retiSel(retiSel),
    .intReq(intReq), .extEnIn(extEnIn), .ackGrant(ackGrant), .ackVec(ackVec)
  );

  localparam logic [7:0] V0 = 8'h3C, V1 = 8'h5A, V2 = 8'h96, VE = 8'hE1;

  // Rank table from R3
  function automatic int rankSrc(input logic [2:0] c, input int p);
    int t [6][3] = '{'{0,1,2}, '{1,0,2}, '{0,2,1}, '{2,1,0}, '{2,0,1}, '{1,2,0}};
    return t[c][p];
  endfunction

  // R4 folding: 6 -> 2, 7 -> 3
  function automatic logic [2:0] effCode(input logic [2:0] c);
    return (c > 3'd5) ? c - 3'd4 : c;
  endfunction

  // 0..2 internal, 3 external, 4 none
  function automatic int expWin(input logic [2:0] c, input logic [2:0] p, input logic [2:0] sv, input logic e);
    logic blk = 1'b0;
    for (int k = 0; k < 3; k++) begin
      int s = rankSrc(c, k);
      if (!blk && p[s] && !sv[s]) return s;
      if (sv[s]) blk = 1'b1;
    end
    if (e && p == 3'b000 && sv == 3'b000) return 3;
    return 4;
  endfunction

  function automatic logic [7:0] vecOf(input int w);
    case (w)
      0: return V0;
      1: return V1;
      2: return V2;
      3: return VE;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (code=%0d svc=%b pend=%b)", tag, act, exp, mCode, mSvc, srcPend);
    end
  endtask

  // Drive one cycle after a falling edge, check before the rising edge, then advance the model
  task automatic step(input logic [2:0] p, input logic e, input logic a, input logic r,
                      input logic [1:0] rs, input logic w, input logic [15:0] ad,
                      input logic [7:0] d, input string tag);
    int win;
    srcPend = p; extPend = e; ackValid = a; retiValid = r; retiSel = rs;
    ioWrEn = w; ioAddr = ad; ioWrData = d;
    #1;
    win = expWin(mCode, p, mSvc, e);
    chk({"R6 intReq ", tag}, {7'd0, intReq}, {7'd0, win != 4});
    chk({"R5 extEnIn ", tag}, {7'd0, extEnIn}, {7'd0, (p == 3'b000 && mSvc == 3'b000)});
    chk({"R7 ackGrant ", tag}, {4'd0, ackGrant}, (a && win < 4) ? 8'(1 << win) : 8'd0);
    chk({"R7 ackVec ", tag}, ackVec, a ? vecOf(win) : 8'd0);
    @(posedge clk);
    if (r && rs < 2'd3) mSvc[rs] = 1'b0;
    if (a && win < 3) mSvc[win] = 1'b1;
    if (w && ad[7:0] == 8'hF4) mCode = effCode(d[2:0]);
    @(negedge clk);
    ioWrEn = 1'b0; ackValid = 1'b0; retiValid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    srcVec = {V2, V1, V0}; extVec = VE;
    srcPend = 0; extPend = 0; ackValid = 0; retiValid = 0; retiSel = 0;
    ioWrEn = 0; ioAddr = 0; ioWrData = 0;
    mCode = 0; mSvc = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    #1;
    chk("R1 intReq", {7'd0, intReq}, 8'd0);
    chk("R1 extEnIn", {7'd0, extEnIn}, 8'd1);
    chk("R1 ackGrant", {4'd0, ackGrant}, 8'd0);
    @(negedge clk);
    // R1: code 0 after reset -> timer wins with all pending
    step(3'b111, 0, 1, 0, 0, 0, 0, 0, "R1 code0 order");
    step(3'b000, 0, 0, 1, 0, 0, 0, 0, "R9 clear timer");

    // R3/R4 exhaustive sweep of codes, pending patterns and external request
    for (int c = 0; c < 8; c++) begin
      step(0, 0, 0, 0, 0, 1, {8'(c * 37), 8'hF4}, {5'b10110, 3'(c)}, "R2 write mirrored");
      for (int p = 0; p < 8; p++) begin
        for (int e = 0; e < 2; e++) begin
          int w = expWin(mCode, 3'(p), mSvc, 1'(e));
          step(3'(p), 1'(e), 1, 0, 0, 0, 0, 0, c > 5 ? "R4 folded order" : "R3 order");
          step(0, 0, 0, w < 3, 2'(w < 3 ? w : 3), 0, 0, 0, "R9 release");
        end
      end
    end

    // R2: write to another low byte is ignored
    step(0, 0, 0, 0, 0, 1, 16'h00F4, 8'h01, "R2 load code 1");
    step(0, 0, 0, 0, 0, 1, 16'h12F5, 8'h03, "R2 other port ignored");
    step(3'b111, 0, 1, 0, 0, 0, 0, 0, "R2 still code 1");
    // R8 nesting: serial in service blocks lower, timer/parallel order under code 1
    step(3'b101, 0, 0, 0, 0, 0, 0, 0, "R8 lower blocked");
    step(3'b101, 1, 1, 0, 0, 0, 0, 0, "R8 lower blocked ack");
    // R10: switch to code 4 (parallel, timer, serial) with serial still in service
    step(0, 0, 0, 0, 0, 1, 16'hFFF4, 8'h04, "R10 code change");
    step(3'b101, 0, 1, 0, 0, 0, 0, 0, "R10 new order nests above");
    // Same-cycle ack and return on different sources (R9)
    step(3'b001, 0, 1, 1, 2'd1, 0, 0, 0, "R9 ack with reti");
    step(3'b000, 0, 0, 1, 2'd3, 0, 0, 0, "R9 reti external no effect");
    step(3'b010, 0, 1, 0, 0, 0, 0, 0, "R9 after external reti");
    // Write and ack in the same cycle: old order governs (R2)
    step(3'b111, 0, 1, 1, 2'd0, 1, 16'h00F4, 8'h07, "R2 write with ack");
    step(3'b111, 0, 1, 0, 0, 0, 0, 0, "R4 code 7 active");

    // Pseudo-random mix of every event
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [15:0] b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr;
      step(a[2:0], a[3], a[4], a[5] & a[6], a[8:7], b[3:0] == 4'd0,
           {b[15:8], b[4] ? 8'hF4 : b[15:8]}, {5'd0, b[7:5]}, "R10 mixed run");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule